// File: doc/BRIEF.md
# Phase-Continuous Cosine Oscillator

This block is a numerically controlled oscillator for driving an external DAC. A 32-bit phase register advances every clock by a programmable increment, wrapping modulo 2^32. The output frequency is therefore the increment times the clock rate divided by 2^32. An increment of 1 at a 125 MHz clock gives roughly 0.0291 Hz. The top 14 phase bits are turned into a 10-bit offset-binary cosine sample through a quarter-wave table folded by quadrant symmetry. The phase MSB is also brought out as a square-wave reference.

A new increment is written by presenting it on the word input with the load strobe high. It is held in a tuning register and used from the next add onward. The phase register is never cleared by a load, so the waveform stays continuous across a frequency change. The sample path is three registers deep.

A small fill controller tracks how far the pipeline has filled after reset. It has four states:
- `FILL_EMPTY`: entered on reset.
- `FILL_ONE`: reached on the first clock after reset.
- `FILL_TWO`: reached on the second clock.
- `FILL_FULL`: reached on the third clock. It then stays in `FILL_FULL` until the next reset.

Each transition is a single step taken on one clock edge with reset low. The valid flag is high only in `FILL_FULL`.

Top module: `nco_cosine_osc`

## Requirements
- R1: While reset is sampled high, the phase register and tuning register clear to 0. After that reset edge, `cos_code` reads 512, `code_valid` reads 0 and `phase_msb` reads 0.
- R2: On every clock edge with reset low, the phase register gains the current tuning register value modulo 2^32.
- R3: When an add carries out of bit 31, the phase register keeps the wrapped remainder and counting continues without a jump.
- R4: Only phase bits 31..18 reach the sample. With an increment of 1 after reset, the sample stays at 1023 for the whole run.
- R5: For a 14-bit phase p, the sample is 512 + s·round(511·|cos(2π(p+0.5)/16384)|), where s is the sign of the cosine. Phase 0 gives 1023 and phase 8192 gives 1. Codes at or above 512 occur for phases in quadrants 0 and 3 (top two bits 00 or 11); codes at or below 512 occur otherwise.
- R6: The cosine is built from a quarter-wave table. With an increment of 2^30, the samples repeat as 1023, 512, 1, 512.
- R7: The word input is captured only on an edge where `freq_load` is high. On other edges, changes on the word input have no effect.
- R8: A captured word is first added on the edge after it is captured. A load never alters the phase register.
- R9: The sample produced from the phase register value after edge k appears on `cos_code` after edge k+3. `code_valid` rises after the third edge following reset and stays high until the next reset.
- R10: `phase_msb` equals bit 31 of the phase register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | New phase increment |
| freq_load | input | 1 | Capture strobe for `freq_word` |
| cos_code | output | 10 | Offset-binary cosine sample |
| code_valid | output | 1 | Pipeline holds samples derived after reset |
| phase_msb | output | 1 | Bit 31 of the phase register |

## Verification
A tuning-word capture and a carry out of the phase register can fall on the same edge. The bench provokes this by loading large increments and toggling the load strobe on consecutive edges, so some captures land exactly on a wrap. On such edges the old increment must produce the wrapped phase, and the new increment must take over only from the following add. A behavioural model checks this on every clock, with samples computed from the cosine formula.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int ACC_W  = 32;
    localparam int PH_W   = 14;
    localparam int CODE_W = 10;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_ONE,
        FILL_TWO,
        FILL_FULL
    } fill_state_t;

    // Magnitude of one quarter-wave entry, rounded to nearest.
    // Half-step offset keeps the four folded quadrants exactly symmetric.
    function automatic int quarter_cos(input int k, input int ph_w, input int code_w);
        real full_turn;
        real ang;
        real amp;
        full_turn = 6.283185307179586;
        ang = full_turn * (real'(k) + 0.5) / real'(1 << ph_w);
        amp = real'((1 << (code_w - 1)) - 1) * $cos(ang);
        return $rtoi(amp + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] word,
    input  logic             load,
    output logic [PH_W-1:0]  phase,
    output logic             msb
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] tw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            tw_q  <= '0;
        end else begin
            acc_q <= acc_q + tw_q;
            if (load) begin
                tw_q <= word;
            end
        end
    end

    assign phase = acc_q[ACC_W-1 -: PH_W];
    assign msb   = acc_q[ACC_W-1];

    p_clear_r1: assert property (@(posedge clk) rst |=> (acc_q == '0 && tw_q == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(tw_q));

    p_keep_phase_r8: assert property (@(posedge clk) disable iff (rst)
        (load && tw_q == '0) |=> $stable(acc_q));

endmodule

// File: rtl/nco_cos_lut.sv
module nco_cos_lut #(
    parameter int PH_W   = 14,
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase,
    output logic [CODE_W-1:0] code
);
    localparam int Q_W   = PH_W - 2;
    localparam int MAG_W = CODE_W - 1;
    localparam int DEPTH = 1 << Q_W;
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic [MAG_W-1:0] rom [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
        localparam int VAL = nco_pkg::quarter_cos(gi, PH_W, CODE_W);
        assign rom[gi] = MAG_W'(VAL);
    end

    logic [1:0]       quad_q;
    logic [Q_W-1:0]   addr_q;
    logic [MAG_W-1:0] mag_q;
    logic             neg_q;

    // Stage 1: quadrant split and address mirroring.
    always_ff @(posedge clk) begin
        if (rst) begin
            quad_q <= '0;
            addr_q <= '0;
        end else begin
            quad_q <= phase[PH_W-1 -: 2];
            addr_q <= phase[PH_W-2] ? ~phase[Q_W-1:0] : phase[Q_W-1:0];
        end
    end

    // Stage 2: table read and sign decision.
    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q <= '0;
            neg_q <= 1'b0;
        end else begin
            mag_q <= rom[addr_q];
            neg_q <= quad_q[1] ^ quad_q[0];
        end
    end

    // Stage 3: offset-binary code.
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= MID;
        end else if (neg_q) begin
            code <= MID - {1'b0, mag_q};
        end else begin
            code <= MID + {1'b0, mag_q};
        end
    end

    p_midscale_r1: assert property (@(posedge clk) rst |=> (code == MID));

endmodule

// File: rtl/nco_fill_fsm.sv
module nco_fill_fsm (
    input  logic clk,
    input  logic rst,
    output logic valid
);
    import nco_pkg::*;

    fill_state_t state_q;
    fill_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        valid   = 1'b0;
        unique case (state_q)
            FILL_EMPTY: state_d = FILL_ONE;
            FILL_ONE:   state_d = FILL_TWO;
            FILL_TWO:   state_d = FILL_FULL;
            FILL_FULL:  valid   = 1'b1;
            default:    state_d = FILL_EMPTY;
        endcase
    end

    p_stay_full_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == FILL_FULL) |=> (state_q == FILL_FULL));

endmodule

// File: rtl/nco_cosine_osc.sv
module nco_cosine_osc #(
    parameter int ACC_W  = nco_pkg::ACC_W,
    parameter int PH_W   = nco_pkg::PH_W,
    parameter int CODE_W = nco_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  freq_word,
    input  logic              freq_load,
    output logic [CODE_W-1:0] cos_code,
    output logic              code_valid,
    output logic              phase_msb
);
    localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] PEAK = {CODE_W{1'b1}};

    logic [PH_W-1:0] phase;

    nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .word  (freq_word),
        .load  (freq_load),
        .phase (phase),
        .msb   (phase_msb)
    );

    nco_cos_lut #(.PH_W(PH_W), .CODE_W(CODE_W)) u_lut (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .code  (cos_code)
    );

    nco_fill_fsm u_fill (
        .clk   (clk),
        .rst   (rst),
        .valid (code_valid)
    );

    p_peak_r5: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(phase, 3) == '0) |-> (cos_code == PEAK));

    p_sign_r5: assert property (@(posedge clk) disable iff (rst)
        code_valid |->
            (($past(phase[PH_W-1], 3) == $past(phase[PH_W-2], 3)) ? (cos_code >= MID)
                                                                 : (cos_code <= MID)));

    p_valid_hold_r9: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> code_valid);

endmodule

// File: tb/tb_nco_cosine_osc.sv
module tb_nco_cosine_osc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] freq_word = '0;
    logic        freq_load = 1'b0;
    logic [9:0]  cos_code;
    logic        code_valid;
    logic        phase_msb;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nco_cosine_osc dut (
        .clk        (clk),
        .rst        (rst),
        .freq_word  (freq_word),
        .freq_load  (freq_load),
        .cos_code   (cos_code),
        .code_valid (code_valid),
        .phase_msb  (phase_msb)
    );

    // Behavioural reference.
    bit [31:0] m_acc;
    bit [31:0] m_tw;
    int        m_fill;
    int        m_ph [3];

    function automatic int exp_code(input int p);
        real v;
        int  mag;
        v   = 511.0 * $cos(6.283185307179586 * (real'(p) + 0.5) / 16384.0);
        mag = $rtoi((v < 0.0 ? -v : v) + 0.5);
        return (v < 0.0) ? 512 - mag : 512 + mag;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc  = '0;
            m_tw   = '0;
            m_fill = 0;
            for (int i = 0; i < 3; i++) m_ph[i] = 0;
        end else begin
            m_ph[2] = m_ph[1];
            m_ph[1] = m_ph[0];
            m_ph[0] = int'(m_acc[31:18]);
            m_acc   = m_acc + m_tw;
            if (freq_load) m_tw = freq_word;
            if (m_fill < 3) m_fill++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(code_valid == (m_fill == 3), "R9 valid", int'(code_valid), int'(m_fill == 3));
            check(phase_msb == m_acc[31], "R10 R2 R3 msb", int'(phase_msb), int'(m_acc[31]));
            if (m_fill == 3) begin
                check(int'(cos_code) == exp_code(m_ph[2]), "R2 R3 R5 R7 R8 sample",
                      int'(cos_code), exp_code(m_ph[2]));
            end
        end
    end

    task automatic reset_and_check();
        rst = 1'b1;
        freq_load = 1'b0;
        repeat (3) @(negedge clk);
        chk_en = 1'b1;
        check(cos_code == 10'd512, "R1 code", int'(cos_code), 512);
        check(code_valid == 1'b0, "R1 valid", int'(code_valid), 0);
        check(phase_msb == 1'b0, "R1 msb", int'(phase_msb), 0);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int seq [6];
        seq = '{1023, 1023, 512, 1, 512, 1023};

        // R1, then R6/R9 with a quarter-turn increment.
        reset_and_check();
        rst = 1'b0;
        freq_word = 32'h4000_0000;
        freq_load = 1'b1;
        @(negedge clk);
        freq_load = 1'b0;
        @(negedge clk);
        check(code_valid == 1'b0, "R9 not yet valid", int'(code_valid), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 0) check(code_valid == 1'b1, "R9 valid rise", int'(code_valid), 1);
            check(int'(cos_code) == seq[i], "R6 R9 quarter pattern", int'(cos_code), seq[i]);
        end

        // R7: word changes without the strobe must be ignored.
        for (int i = 0; i < 12; i++) begin
            freq_word = 32'h0123_4567 + i;
            @(negedge clk);
        end
        check(int'(cos_code) == 1023 || int'(cos_code) == 512 || int'(cos_code) == 1,
              "R7 pattern kept", int'(cos_code), 1023);

        // R3/R8: captures coinciding with wraps.
        for (int i = 0; i < 200; i++) begin
            freq_word = (i % 2 == 0) ? 32'hC000_0001 : 32'hF123_4567;
            freq_load = (i % 3 != 2);
            @(negedge clk);
        end
        freq_load = 1'b0;
        for (int i = 0; i < 300; i++) begin
            freq_word = $urandom;
            freq_load = ($urandom % 4) == 0;
            @(negedge clk);
        end
        freq_load = 1'b0;
        repeat (10) @(negedge clk);

        // R1 mid-run, then R4 with the smallest increment.
        reset_and_check();
        rst = 1'b0;
        freq_word = 32'd1;
        freq_load = 1'b1;
        @(negedge clk);
        freq_load = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            check(cos_code == 10'd1023, "R4 low bits dropped", int'(cos_code), 1023);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule